// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Controller

This block sits beside a two-port shared memory. It watches the control and address signals of both ports and keeps one active-low interrupt flag for each port. The two top addresses of the shared space serve as mailboxes. Port A's mailbox is the address with every bit set except bit 0. Port B's mailbox is the address with every bit set. When one port writes the other port's mailbox, it raises that port's interrupt. The interrupted port clears its flag by reading its own mailbox. The mailbox bytes remain ordinary storage in the memory, so no data passes through this block. Systems that do not use interrupts can ignore the flags and use both addresses as plain memory.

Each port presents active-low select, output-enable and write strobes, an address and an active-low busy indication. The busy input comes from the collision arbiter. While a port's busy is low, the mailbox actions that port would cause are suppressed. Every decision is taken on the rising clock edge. Each flag is a two-state machine with the states FLAG_QUIET (output high) and FLAG_RAISED (output low). There are three transitions: a set moves the flag from quiet to raised, a clear without a set moves it from raised to quiet, and in every other case the state is held. Synchronous reset forces both machines into FLAG_QUIET.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) drives both `a_irq_n` and `b_irq_n` high after that edge, whatever their previous state.
- R2: A write by port B raises port A's flag: `a_irq_n` goes low after the edge that samples `b_sel_n`=0, `b_wr_n`=0, `b_busy_n`=1 and `b_addr` equal to all ones except bit 0.
- R3: Port A clears its flag by accessing all ones except bit 0 with `a_sel_n`=0 and `a_oe_n`=0. The value of `a_wr_n` does not matter. A write by port A to that address with `a_oe_n`=1 does not clear the flag.
- R4: A write by port A raises port B's flag: `b_irq_n` goes low after the edge that samples `a_sel_n`=0, `a_wr_n`=0, `a_busy_n`=1 and `a_addr` equal to all ones.
- R5: Port B clears its flag by accessing the all-ones address with `b_sel_n`=0 and `b_oe_n`=0.
- R6: Both flags are active low. A flag changes only on the clock edge that samples a qualifying access and holds its value in every other cycle.
- R7: A low busy on the writing port blocks the set: the target flag is unchanged.
- R8: A low busy on the reading port blocks the clear: its flag stays low.
- R9: When a set and a clear of the same flag are sampled on the same edge, the set wins and the flag is low after that edge.
- R10: The following have no effect on either flag: accesses to any other address, a read of the other port's mailbox, and strobes given while the port's select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_sel_n | input | 1 | Port A select, active low |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_wr_n | input | 1 | Port A write strobe, active low |
| a_busy_n | input | 1 | Port A collision busy, active low |
| a_addr | input | AW | Port A address |
| b_sel_n | input | 1 | Port B select, active low |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_wr_n | input | 1 | Port B write strobe, active low |
| b_busy_n | input | 1 | Port B collision busy, active low |
| b_addr | input | AW | Port B address |
| a_irq_n | output | 1 | Port A interrupt flag, active low |
| b_irq_n | output | 1 | Port B interrupt flag, active low |

## Verification
The assertions check the flag state machines on every cycle:
- a sampled set always leaves the flag low;
- a lone clear leaves it high;
- a cycle with neither leaves it unchanged;
- a low busy on the acting port never lets port A's flag move.

The bench scenarios are needed to show the rest:
- the address decode picks the correct mailbox for each port;
- the write strobe is ignored when clearing, but output enable is required;
- accesses to other addresses, to the wrong mailbox or without select change nothing;
- set beats clear when both arrive together.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic {
        FLAG_QUIET  = 1'b0,
        FLAG_RAISED = 1'b1
    } flag_state_e;

    localparam int NUM_PORTS = 2;

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode #(
    parameter int          AW       = 17,
    parameter logic [AW-1:0] OWN_BOX  = '1,
    parameter logic [AW-1:0] PEER_BOX = '1
) (
    input  logic          sel_n,
    input  logic          oe_n,
    input  logic          wr_n,
    input  logic          busy_n,
    input  logic [AW-1:0] addr,
    output logic          post_peer,
    output logic          ack_own
);

    logic hit_own;
    logic hit_peer;
    logic selected;

    always_comb begin
        selected  = !sel_n;
        hit_own   = (addr == OWN_BOX);
        hit_peer  = (addr == PEER_BOX);
        // a write to the other port's box posts a message
        post_peer = selected && !wr_n && hit_peer && busy_n;
        // any access with output enable to the own box acknowledges
        ack_own   = selected && !oe_n && hit_own && busy_n;
    end

endmodule

// File: rtl/mbx_flag_fsm.sv
module mbx_flag_fsm
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic clr_req,
    output logic irq_n
);

    flag_state_e state_q;
    flag_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_QUIET: begin
                if (set_req) state_d = FLAG_RAISED;
            end
            FLAG_RAISED: begin
                if (clr_req && !set_req) state_d = FLAG_QUIET;
            end
            default: state_d = FLAG_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= FLAG_QUIET;
        else     state_q <= state_d;
    end

    always_comb begin
        irq_n = (state_q != FLAG_RAISED);
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> irq_n);                                        // R1
    AST_SET_RAISES: assert property (@(posedge clk) disable iff (rst)
        set_req |=> !irq_n);                                   // R9
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !set_req) |=> irq_n);                      // R6
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!set_req && !clr_req) |=> $stable(irq_n));            // R6

endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
    import mbx_pkg::*;
#(
    parameter int AW = 17
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          a_sel_n,
    input  logic          a_oe_n,
    input  logic          a_wr_n,
    input  logic          a_busy_n,
    input  logic [AW-1:0] a_addr,
    input  logic          b_sel_n,
    input  logic          b_oe_n,
    input  logic          b_wr_n,
    input  logic          b_busy_n,
    input  logic [AW-1:0] b_addr,
    output logic          a_irq_n,
    output logic          b_irq_n
);

    localparam logic [AW-1:0] BOX_B = '1;
    localparam logic [AW-1:0] BOX_A = {{(AW-1){1'b1}}, 1'b0};

    logic          sel_n_v  [NUM_PORTS];
    logic          oe_n_v   [NUM_PORTS];
    logic          wr_n_v   [NUM_PORTS];
    logic          busy_n_v [NUM_PORTS];
    logic [AW-1:0] addr_v   [NUM_PORTS];
    logic          post_v   [NUM_PORTS];
    logic          ack_v    [NUM_PORTS];
    logic          irq_n_v  [NUM_PORTS];

    always_comb begin
        sel_n_v[0]  = a_sel_n;   sel_n_v[1]  = b_sel_n;
        oe_n_v[0]   = a_oe_n;    oe_n_v[1]   = b_oe_n;
        wr_n_v[0]   = a_wr_n;    wr_n_v[1]   = b_wr_n;
        busy_n_v[0] = a_busy_n;  busy_n_v[1] = b_busy_n;
        addr_v[0]   = a_addr;    addr_v[1]   = b_addr;
        a_irq_n     = irq_n_v[0];
        b_irq_n     = irq_n_v[1];
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        localparam logic [AW-1:0] OWN  = (p == 0) ? BOX_A : BOX_B;
        localparam logic [AW-1:0] PEER = (p == 0) ? BOX_B : BOX_A;

        mbx_port_decode #(
            .AW       (AW),
            .OWN_BOX  (OWN),
            .PEER_BOX (PEER)
        ) u_dec (
            .sel_n     (sel_n_v[p]),
            .oe_n      (oe_n_v[p]),
            .wr_n      (wr_n_v[p]),
            .busy_n    (busy_n_v[p]),
            .addr      (addr_v[p]),
            .post_peer (post_v[p]),
            .ack_own   (ack_v[p])
        );

        mbx_flag_fsm u_flag (
            .clk     (clk),
            .rst     (rst),
            .set_req (post_v[NUM_PORTS-1-p]),
            .clr_req (ack_v[p]),
            .irq_n   (irq_n_v[p])
        );
    end

    AST_BUSY_BLOCKS_SET: assert property (@(posedge clk) disable iff (rst)
        (!b_busy_n && a_irq_n) |=> a_irq_n);                   // R7
    AST_BUSY_BLOCKS_CLR: assert property (@(posedge clk) disable iff (rst)
        (!a_busy_n && !a_irq_n) |=> !a_irq_n);                 // R8

endmodule

// File: tb/mbx_irq_ctrl_tb.sv
module mbx_irq_ctrl_tb;

    localparam int AW = 17;
    localparam logic [AW-1:0] TOP  = '1;
    localparam logic [AW-1:0] TOP1 = {{(AW-1){1'b1}}, 1'b0};
    localparam logic [AW-1:0] OTHER = TOP - 2;

    typedef struct packed {
        logic a_n;
        logic b_n;
        logic [7:0] req;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a_sel_n = 1, a_oe_n = 1, a_wr_n = 1, a_busy_n = 1;
    logic b_sel_n = 1, b_oe_n = 1, b_wr_n = 1, b_busy_n = 1;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic a_irq_n, b_irq_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    exp_t sb_q[$];

    always #10 clk = ~clk;

    mbx_irq_ctrl #(.AW(AW)) u_dut (
        .clk(clk), .rst(rst),
        .a_sel_n(a_sel_n), .a_oe_n(a_oe_n), .a_wr_n(a_wr_n),
        .a_busy_n(a_busy_n), .a_addr(a_addr),
        .b_sel_n(b_sel_n), .b_oe_n(b_oe_n), .b_wr_n(b_wr_n),
        .b_busy_n(b_busy_n), .b_addr(b_addr),
        .a_irq_n(a_irq_n), .b_irq_n(b_irq_n)
    );

    // driver: sets inputs at the falling edge and queues the
    // flag values expected after the next rising edge
    task automatic step(
        input logic r,
        input logic as, input logic ao, input logic aw, input logic ab,
        input logic [AW-1:0] aa,
        input logic bs, input logic bo, input logic bw, input logic bb,
        input logic [AW-1:0] ba,
        input logic ea, input logic eb, input logic [7:0] req);
        @(negedge clk);
        rst = r;
        a_sel_n = as; a_oe_n = ao; a_wr_n = aw; a_busy_n = ab; a_addr = aa;
        b_sel_n = bs; b_oe_n = bo; b_wr_n = bw; b_busy_n = bb; b_addr = ba;
        sb_q.push_back('{a_n: ea, b_n: eb, req: req});
    endtask

    // monitor: compares shortly after each rising edge
    always begin
        @(posedge clk);
        #2;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (a_irq_n !== e.a_n || b_irq_n !== e.b_n) begin
                fails++;
                $display("FAIL R%0d: flags a=%b b=%b, expected a=%b b=%b",
                         e.req, a_irq_n, b_irq_n, e.a_n, e.b_n);
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run hung, actual not done, expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        step(1, 1,1,1,1,'0,    1,1,1,1,'0,    1,1, 8'd1);
        // R6 idle holds
        step(0, 1,1,1,1,'0,    1,1,1,1,'0,    1,1, 8'd6);
        // R2 B writes A's box
        step(0, 1,1,1,1,'0,    0,1,0,1,TOP1,  0,1, 8'd2);
        // R6 hold low
        step(0, 1,1,1,1,'0,    1,1,1,1,'0,    0,1, 8'd6);
        // R3 A writes own box without output enable: no clear
        step(0, 0,1,0,1,TOP1,  1,1,1,1,'0,    0,1, 8'd3);
        // R3 A accesses own box with oe, write strobe low: clears
        step(0, 0,0,0,1,TOP1,  1,1,1,1,'0,    1,1, 8'd3);
        // R4 A writes B's box
        step(0, 0,1,0,1,TOP,   1,1,1,1,'0,    1,0, 8'd4);
        // R10 B reads A's box: no effect
        step(0, 1,1,1,1,'0,    0,0,1,1,TOP1,  1,0, 8'd10);
        // R8 B reads own box while busy: blocked
        step(0, 1,1,1,1,'0,    0,0,1,0,TOP,   1,0, 8'd8);
        // R5 B reads own box: clears
        step(0, 1,1,1,1,'0,    0,0,1,1,TOP,   1,1, 8'd5);
        // R7 A writes B's box while busy: blocked
        step(0, 0,1,0,0,TOP,   1,1,1,1,'0,    1,1, 8'd7);
        // R7 B writes A's box while busy: blocked
        step(0, 1,1,1,1,'0,    0,1,0,0,TOP1,  1,1, 8'd7);
        // R10 other address
        step(0, 0,1,0,1,OTHER, 0,1,0,1,OTHER, 1,1, 8'd10);
        // R10 strobes without select
        step(0, 1,1,0,1,TOP,   1,1,0,1,TOP1,  1,1, 8'd10);
        // R4 raise B again
        step(0, 0,1,0,1,TOP,   1,1,1,1,'0,    1,0, 8'd4);
        // R9 set and clear of B together: set wins
        step(0, 0,1,0,1,TOP,   0,0,1,1,TOP,   1,0, 8'd9);
        // R5 clear B
        step(0, 1,1,1,1,'0,    0,0,1,1,TOP,   1,1, 8'd5);
        // R9 set and clear of A together from quiet: set wins
        step(0, 0,0,1,1,TOP1,  0,1,0,1,TOP1,  0,1, 8'd9);
        // R2 and R4 both raised in one cycle
        step(0, 0,1,0,1,TOP,   0,1,0,1,TOP1,  0,0, 8'd2);
        // R1 reset while both raised
        step(1, 1,1,1,1,'0,    1,1,1,1,'0,    1,1, 8'd1);
        step(0, 1,1,1,1,'0,    1,1,1,1,'0,    1,1, 8'd6);
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule